// File: doc/BRIEF.md
# JTAG Debug-Port Register Responder

This block sits behind a JTAG TAP controller on the target side of a debug port. The TAP controller supplies two kinds of completed scan: a 4-bit instruction, and a 35-bit data scan. The responder holds the debug-port register file, which covers:

- a fixed identification word;
- a bank-selected register window holding control/status and related registers;
- the select register;
- a read buffer.

It also forms the 35-bit word that the TAP shifts out during the next data scan. That word carries a 32-bit data field above a 3-bit acknowledge.

Reads are posted. A debug-port read places its result in the read buffer, and the next scan shifts that result out. Access-port scans are forwarded as a single-cycle request. The request carries the register address, direction and write data, together with the access-port number and bank taken from the select register. Read data that comes back from the access port is loaded into the read buffer. An access-port error sets a sticky flag, which the host clears either by a write-one to control/status or by an abort scan. Power-up requests written to control/status are acknowledged one cycle later.

Top module: `jtag_dp_responder`

## Requirements
- R1: After reset, the select register, control/status and the read buffer are all zero, the instruction is BYPASS (4'hF), and `dr_shift_out` is 35'h2: data 0 with acknowledge OK.
- R2: The layout of a data scan is fixed.
  - Scan bit 0 is the direction: 1 means read.
  - Scan bits [2:1] are the register word address: 0 identification, 1 banked window, 2 select, 3 read buffer.
  - Scan bits [34:3] are the write data.
  - The output word is {data[31:0], ack[2:0]}, where OK is 3'b010 and WAIT is 3'b001.
  - Instruction codes: 4'hA debug-port access, 4'hB access-port access, 4'h8 abort.
- R3: A debug-port read of word 0, 1 or 2 loads the read value into the read buffer. The value appears in the data field of `dr_shift_out` right after that scan.
- R4: A read of word 3 returns the current read-buffer value and leaves the buffer unchanged. Writes never change the read buffer.
- R5: The select register stores all 32 written bits and reads them back. Bits [31:24] give the access-port number, bits [7:4] the access-port bank and bits [3:0] the debug-port bank.
- R6: The debug-port bank chooses the register at word 1.
  - Bank 0 is control/status.
  - Bank 1 is a read/write link-control register.
  - Bank 2 is the target identity and bank 3 the protocol identity.
  - Bank 4 is an event register that reads 0.
  - Banks 5 to 15 read 0 and ignore writes.
- R7: The identification word, the target identity and the protocol identity are parameter constants. Writes to them have no effect.
- R8: In control/status, write bits 30 and 28 are the system and debug power-up requests and read back as written. Read bits 31 and 29 are their acknowledges, which follow the requests one cycle later. So writing 32'h50000000, waiting one idle cycle, then reading returns 32'hF0000000.
- R9: Control/status bit 5 is a sticky error, set by an access-port error response. It is cleared by writing 1 to bit 5 of control/status, or by an abort scan whose data bit 2 is 1. Writing 0 to bit 5 leaves it set. Setting takes priority over clearing.
- R10: An access-port scan accepted while `ap_busy` is low gives acknowledge OK. In the cycle after the scan it raises `ap_req` for exactly one cycle, with address, direction and write data from the scan and number and bank from the select register.
- R11: An access-port scan while `ap_busy` is high gives acknowledge WAIT and raises no request.
- R12: `ap_rdata` delivered with `ap_rvalid` for an outstanding access-port read is loaded into the read buffer. It then shows in the data field and is returned by a read-buffer read.
- R13: Data scans under any other instruction (for example 4'hE) change no register and leave `dr_shift_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_upd | input | 1 | Pulse: a completed instruction scan |
| ir_val | input | 4 | Captured instruction |
| dr_upd | input | 1 | Pulse: a completed data scan |
| dr_capt | input | 35 | Captured data scan |
| dr_shift_out | output | 35 | Word to shift out on the next data scan |
| ap_req | output | 1 | Access-port request strobe |
| ap_sel | output | 8 | Access-port number |
| ap_bank | output | 4 | Access-port register bank |
| ap_addr | output | 2 | Access-port register word address |
| ap_wdata | output | 32 | Access-port write data |
| ap_rnw | output | 1 | Access-port direction, 1 for read |
| ap_busy | input | 1 | Access port cannot take a request |
| ap_rvalid | input | 1 | Access-port response strobe |
| ap_rdata | input | 32 | Access-port read data |
| ap_err | input | 1 | Access-port response is an error |

## Verification
Every stored register reaches the ports only through a later read scan. A wrong select bank or a lost control/status bit therefore appears in the data field of `dr_shift_out` one clock after the next read of that word, and never before it. A read buffer that a write or a read-buffer read corrupts shows up on the very next scan. A faulty busy path shows on `ap_req` in the cycle after the scan, and a faulty sticky or power handshake bit shows on the first control/status read after it settles.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int DW     = 32;
  localparam int IRW    = 4;
  localparam int AW     = 2;
  localparam int SCAN_W = DW + AW + 1;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  localparam logic [IRW-1:0] IR_ABORT  = 4'h8;
  localparam logic [IRW-1:0] IR_DPACC  = 4'hA;
  localparam logic [IRW-1:0] IR_APACC  = 4'hB;
  localparam logic [IRW-1:0] IR_BYPASS = 4'hF;

  localparam logic [AW-1:0] W_IDENT = 2'd0;
  localparam logic [AW-1:0] W_BANK  = 2'd1;
  localparam logic [AW-1:0] W_SEL   = 2'd2;
  localparam logic [AW-1:0] W_RDBUF = 2'd3;

  localparam logic [3:0] BK_CTRL  = 4'd0;
  localparam logic [3:0] BK_LINK  = 4'd1;
  localparam logic [3:0] BK_TGTID = 4'd2;
  localparam logic [3:0] BK_PROT  = 4'd3;

  // Control/status bit positions (fixed by the protocol)
  localparam int CS_SYS_ACK = 31;
  localparam int CS_SYS_REQ = 30;
  localparam int CS_DBG_ACK = 29;
  localparam int CS_DBG_REQ = 28;
  localparam int CS_STICKY  = 5;
  localparam int ABT_CLRERR = 2;

  function automatic logic [DW-1:0] pack_ctrl(input logic sys_ack, input logic sys_req,
                                              input logic dbg_ack, input logic dbg_req,
                                              input logic sticky);
    logic [DW-1:0] v;
    v = '0;
    v[CS_SYS_ACK] = sys_ack;
    v[CS_SYS_REQ] = sys_req;
    v[CS_DBG_ACK] = dbg_ack;
    v[CS_DBG_REQ] = dbg_req;
    v[CS_STICKY]  = sticky;
    return v;
  endfunction

  function automatic logic [7:0] sel_port(input logic [DW-1:0] s);
    return s[31:24];
  endfunction

  function automatic logic [3:0] sel_apbank(input logic [DW-1:0] s);
    return s[7:4];
  endfunction

  function automatic logic [3:0] sel_dpbank(input logic [DW-1:0] s);
    return s[3:0];
  endfunction
endpackage

// File: rtl/dpr_scan_decode.sv
module dpr_scan_decode
  import dpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_upd,
  input  logic [IRW-1:0]    ir_val,
  input  logic              dr_upd,
  input  logic [SCAN_W-1:0] dr_capt,
  output logic              dp_wr,
  output logic              dp_rd,
  output logic              ap_acc,
  output logic              abort_wr,
  output logic [AW-1:0]     reg_a,
  output logic              rnw,
  output logic [DW-1:0]     wdata
);
  logic [IRW-1:0] ir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ir_q <= IR_BYPASS;
    else if (ir_upd) ir_q <= ir_val;
  end

  always_comb begin
    rnw      = dr_capt[0];
    reg_a    = dr_capt[AW:1];
    wdata    = dr_capt[SCAN_W-1:AW+1];
    dp_wr    = dr_upd && (ir_q == IR_DPACC) && !rnw;
    dp_rd    = dr_upd && (ir_q == IR_DPACC) && rnw;
    ap_acc   = dr_upd && (ir_q == IR_APACC);
    abort_wr = dr_upd && (ir_q == IR_ABORT);
  end

  // R13: scans under other instructions produce no strobe
  a_r13_other_ir_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_upd && ir_q != IR_DPACC && ir_q != IR_APACC && ir_q != IR_ABORT)
      |-> !(dp_wr || dp_rd || ap_acc || abort_wr));
endmodule

// File: rtl/dpr_regfile.sv
module dpr_regfile
  import dpr_pkg::*;
#(
  parameter logic [DW-1:0] IDENT_VAL = 32'h2BA0_1477,
  parameter logic [DW-1:0] TGTID_VAL = 32'h1002_0041,
  parameter logic [DW-1:0] PROT_VAL  = 32'h0000_0001,
  parameter logic [DW-1:0] LINK_RST  = 32'h0000_0000
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dp_wr,
  input  logic          dp_rd,
  input  logic          abort_wr,
  input  logic [AW-1:0] reg_a,
  input  logic [DW-1:0] wdata,
  input  logic          err_set,
  input  logic          ap_load,
  input  logic [DW-1:0] ap_rdata,
  output logic [DW-1:0] select_q,
  output logic [DW-1:0] rdbuff_q
);
  logic [DW-1:0] link_q;
  logic          sys_req, dbg_req, sys_ack, dbg_ack, sticky;
  logic [DW-1:0] bank_val, rd_val;
  logic [3:0]    dpbank;
  logic          ctrl_wr, sticky_clr;

  assign dpbank = sel_dpbank(select_q);
  assign ctrl_wr = dp_wr && (reg_a == W_BANK) && (dpbank == BK_CTRL);
  assign sticky_clr = (ctrl_wr && wdata[CS_STICKY]) || (abort_wr && wdata[ABT_CLRERR]);

  always_comb begin
    case (dpbank)
      BK_CTRL:  bank_val = pack_ctrl(sys_ack, sys_req, dbg_ack, dbg_req, sticky);
      BK_LINK:  bank_val = link_q;
      BK_TGTID: bank_val = TGTID_VAL;
      BK_PROT:  bank_val = PROT_VAL;
      default:  bank_val = '0;
    endcase
    case (reg_a)
      W_IDENT: rd_val = IDENT_VAL;
      W_BANK:  rd_val = bank_val;
      W_SEL:   rd_val = select_q;
      default: rd_val = rdbuff_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      select_q <= '0;
      link_q   <= LINK_RST;
      sys_req  <= 1'b0;
      dbg_req  <= 1'b0;
      sys_ack  <= 1'b0;
      dbg_ack  <= 1'b0;
      sticky   <= 1'b0;
      rdbuff_q <= '0;
    end else begin
      sys_ack <= sys_req;
      dbg_ack <= dbg_req;
      if (dp_wr && reg_a == W_SEL) select_q <= wdata;
      if (ctrl_wr) begin
        sys_req <= wdata[CS_SYS_REQ];
        dbg_req <= wdata[CS_DBG_REQ];
      end
      if (dp_wr && reg_a == W_BANK && dpbank == BK_LINK) link_q <= wdata;
      if (err_set)         sticky <= 1'b1;
      else if (sticky_clr) sticky <= 1'b0;
      if (ap_load)                          rdbuff_q <= ap_rdata;
      else if (dp_rd && reg_a != W_RDBUF)   rdbuff_q <= rd_val;
    end
  end

  // R4: read-buffer read has no side effect
  a_r4_rdbuf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd && reg_a == W_RDBUF && !ap_load) |=> $stable(rdbuff_q));
  // R9: clear without a concurrent error leaves the flag low
  a_r9_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr && !err_set) |=> !sticky);
  // R9: an error response always sets the flag
  a_r9_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> sticky);
  // R8: a held request is acknowledged
  a_r8_pwr_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_req && $past(sys_req) && dbg_req && $past(dbg_req)) |-> (sys_ack && dbg_ack));
endmodule

// File: rtl/dpr_ap_bridge.sv
module dpr_ap_bridge
  import dpr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ap_acc,
  input  logic          rnw,
  input  logic [AW-1:0] reg_a,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] select_q,
  input  logic          ap_busy,
  input  logic          ap_rvalid,
  input  logic          ap_err,
  output logic          ap_req,
  output logic [7:0]    ap_sel,
  output logic [3:0]    ap_bank,
  output logic [AW-1:0] ap_addr,
  output logic [DW-1:0] ap_wdata,
  output logic          ap_rnw,
  output logic [2:0]    acc_ack,
  output logic          ap_load,
  output logic          err_set
);
  logic accept, pend_rd;

  assign accept  = ap_acc && !ap_busy;
  assign acc_ack = ap_busy ? ACK_WAIT : ACK_OK;
  assign ap_load = ap_rvalid && pend_rd;
  assign err_set = ap_rvalid && ap_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_req   <= 1'b0;
      ap_sel   <= '0;
      ap_bank  <= '0;
      ap_addr  <= '0;
      ap_wdata <= '0;
      ap_rnw   <= 1'b0;
      pend_rd  <= 1'b0;
    end else begin
      ap_req <= accept;
      if (accept) begin
        ap_sel   <= sel_port(select_q);
        ap_bank  <= sel_apbank(select_q);
        ap_addr  <= reg_a;
        ap_wdata <= wdata;
        ap_rnw   <= rnw;
        pend_rd  <= rnw;
      end else if (ap_rvalid) begin
        pend_rd  <= 1'b0;
      end
    end
  end

  // R11: a busy port receives no request
  a_r11_wait_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_acc && ap_busy) |=> !ap_req);
  // R10: accepted scan issues a request carrying its direction
  a_r10_req_issued: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_acc && !ap_busy) |=> (ap_req && ap_rnw == $past(rnw) && ap_addr == $past(reg_a)));
endmodule

// File: rtl/jtag_dp_responder.sv
module jtag_dp_responder
  import dpr_pkg::*;
#(
  parameter logic [31:0] IDENT_VAL = 32'h2BA0_1477,
  parameter logic [31:0] TGTID_VAL = 32'h1002_0041,
  parameter logic [31:0] PROT_VAL  = 32'h0000_0001,
  parameter logic [31:0] LINK_RST  = 32'h0000_0000
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_upd,
  input  logic [3:0]  ir_val,
  input  logic        dr_upd,
  input  logic [34:0] dr_capt,
  output logic [34:0] dr_shift_out,
  output logic        ap_req,
  output logic [7:0]  ap_sel,
  output logic [3:0]  ap_bank,
  output logic [1:0]  ap_addr,
  output logic [31:0] ap_wdata,
  output logic        ap_rnw,
  input  logic        ap_busy,
  input  logic        ap_rvalid,
  input  logic [31:0] ap_rdata,
  input  logic        ap_err
);
  logic          dp_wr, dp_rd, ap_acc, abort_wr, rnw;
  logic [AW-1:0] reg_a;
  logic [DW-1:0] wdata, select_q, rdbuff_q;
  logic          err_set, ap_load;
  logic [2:0]    acc_ack, ack_q;

  dpr_scan_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ir_upd(ir_upd), .ir_val(ir_val),
    .dr_upd(dr_upd), .dr_capt(dr_capt), .dp_wr(dp_wr), .dp_rd(dp_rd),
    .ap_acc(ap_acc), .abort_wr(abort_wr), .reg_a(reg_a), .rnw(rnw), .wdata(wdata)
  );

  dpr_regfile #(
    .IDENT_VAL(IDENT_VAL), .TGTID_VAL(TGTID_VAL), .PROT_VAL(PROT_VAL), .LINK_RST(LINK_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .dp_wr(dp_wr), .dp_rd(dp_rd), .abort_wr(abort_wr),
    .reg_a(reg_a), .wdata(wdata), .err_set(err_set), .ap_load(ap_load),
    .ap_rdata(ap_rdata), .select_q(select_q), .rdbuff_q(rdbuff_q)
  );

  dpr_ap_bridge u_ap (
    .clk(clk), .rst_n(rst_n), .ap_acc(ap_acc), .rnw(rnw), .reg_a(reg_a),
    .wdata(wdata), .select_q(select_q), .ap_busy(ap_busy), .ap_rvalid(ap_rvalid),
    .ap_err(ap_err), .ap_req(ap_req), .ap_sel(ap_sel), .ap_bank(ap_bank),
    .ap_addr(ap_addr), .ap_wdata(ap_wdata), .ap_rnw(ap_rnw), .acc_ack(acc_ack),
    .ap_load(ap_load), .err_set(err_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ack_q <= ACK_OK;
    else if (ap_acc)                       ack_q <= acc_ack;
    else if (dp_wr || dp_rd || abort_wr)   ack_q <= ACK_OK;
  end

  assign dr_shift_out = {rdbuff_q, ack_q};

  // R2: only OK or WAIT is ever presented
  a_r2_ack_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_shift_out[2:0] == ACK_OK) || (dr_shift_out[2:0] == ACK_WAIT));
  // R7: identification read returns the constant on the next scan
  a_r7_ident_const: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd && reg_a == W_IDENT && !ap_load) |=> (dr_shift_out[34:3] == IDENT_VAL));
  // R13: a scan that decodes to nothing leaves the output alone
  a_r13_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_wr && !dp_rd && !ap_acc && !abort_wr && !ap_rvalid) |=> $stable(dr_shift_out));
endmodule

// File: tb/jtag_dp_responder_tb.sv
`timescale 1ns/1ps
module jtag_dp_responder_tb;
  localparam logic [31:0] PID  = 32'h2BA0_1477;
  localparam logic [31:0] TID  = 32'h1002_0041;
  localparam logic [31:0] LPID = 32'h0000_0001;
  localparam logic [2:0]  OK   = 3'b010;
  localparam logic [2:0]  WT   = 3'b001;
  localparam int NV = 20;
  // {rnw, word, wdata, expected data field after the scan}
  localparam logic [66:0] VEC [NV] = '{
    {1'b1, 2'd0, 32'h0,          PID},
    {1'b0, 2'd2, 32'h0F00_00F1,  PID},
    {1'b1, 2'd2, 32'h0,          32'h0F00_00F1},
    {1'b0, 2'd1, 32'h0000_0300,  32'h0F00_00F1},
    {1'b1, 2'd1, 32'h0,          32'h0000_0300},
    {1'b0, 2'd2, 32'h2,          32'h0000_0300},
    {1'b1, 2'd1, 32'h0,          TID},
    {1'b0, 2'd1, 32'hFFFF_FFFF,  TID},
    {1'b1, 2'd1, 32'h0,          TID},
    {1'b0, 2'd2, 32'h3,          TID},
    {1'b1, 2'd1, 32'h0,          LPID},
    {1'b0, 2'd2, 32'h4,          LPID},
    {1'b1, 2'd1, 32'h0,          32'h0},
    {1'b0, 2'd2, 32'h7,          32'h0},
    {1'b0, 2'd1, 32'h0000_1234,  32'h0},
    {1'b0, 2'd2, 32'h1,          32'h0},
    {1'b1, 2'd1, 32'h0,          32'h0000_0300},
    {1'b0, 2'd0, 32'hFFFF_FFFF,  32'h0000_0300},
    {1'b1, 2'd0, 32'h0,          PID},
    {1'b1, 2'd3, 32'h0,          PID}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ir_upd = 1'b0, dr_upd = 1'b0;
  logic [3:0] ir_val = 4'h0;
  logic [34:0] dr_capt = '0;
  logic [34:0] dr_shift_out;
  logic ap_req, ap_rnw;
  logic [7:0] ap_sel;
  logic [3:0] ap_bank;
  logic [1:0] ap_addr;
  logic [31:0] ap_wdata;
  logic ap_busy = 1'b0, ap_rvalid = 1'b0, ap_err = 1'b0;
  logic [31:0] ap_rdata = '0;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  jtag_dp_responder #(.IDENT_VAL(PID), .TGTID_VAL(TID), .PROT_VAL(LPID)) u_dut (
    .clk(clk), .rst_n(rst_n), .ir_upd(ir_upd), .ir_val(ir_val), .dr_upd(dr_upd),
    .dr_capt(dr_capt), .dr_shift_out(dr_shift_out), .ap_req(ap_req), .ap_sel(ap_sel),
    .ap_bank(ap_bank), .ap_addr(ap_addr), .ap_wdata(ap_wdata), .ap_rnw(ap_rnw),
    .ap_busy(ap_busy), .ap_rvalid(ap_rvalid), .ap_rdata(ap_rdata), .ap_err(ap_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic scan_ir(input logic [3:0] code);
    @(negedge clk); ir_upd = 1'b1; ir_val = code;
    @(negedge clk); ir_upd = 1'b0;
  endtask

  // returns at the negedge after the capturing edge
  task automatic scan_dr(input logic rnw, input logic [1:0] w, input logic [31:0] d);
    @(negedge clk); dr_upd = 1'b1; dr_capt = {d, w, rnw};
    @(negedge clk); dr_upd = 1'b0;
  endtask

  task automatic ap_respond(input logic [31:0] d, input logic err);
    @(negedge clk); ap_rvalid = 1'b1; ap_rdata = d; ap_err = err;
    @(negedge clk); ap_rvalid = 1'b0; ap_err = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 output", {29'b0, dr_shift_out}, {29'b0, 32'h0, OK});
    check("R1 ap_req", {63'b0, ap_req}, 64'h0);
    scan_dr(1'b1, 2'd2, 32'h0);
    check("R1 bypass scan ignored", {29'b0, dr_shift_out}, {29'b0, 32'h0, OK});
    scan_ir(4'hA);
    scan_dr(1'b1, 2'd2, 32'h0);
    check("R1 select zero", {29'b0, dr_shift_out}, {29'b0, 32'h0, OK});
    scan_dr(1'b1, 2'd1, 32'h0);
    check("R1 ctrl zero", {29'b0, dr_shift_out}, {29'b0, 32'h0, OK});

    // R2 R3 R4 R5 R6 R7 via table
    for (int i = 0; i < NV; i++) begin
      scan_dr(VEC[i][66], VEC[i][65:64], VEC[i][63:32]);
      check($sformatf("R2/R3/R4/R5/R6/R7 vec %0d", i),
            {29'b0, dr_shift_out}, {29'b0, VEC[i][31:0], OK});
    end
    scan_dr(1'b1, 2'd3, 32'h0);
    check("R4 second rdbuf read", {29'b0, dr_shift_out}, {29'b0, PID, OK});

    // R13: scans under another instruction are ignored
    scan_ir(4'hE);
    scan_dr(1'b0, 2'd2, 32'h0000_00AA);
    check("R13 output unchanged", {29'b0, dr_shift_out}, {29'b0, PID, OK});
    scan_ir(4'hA);
    scan_dr(1'b1, 2'd2, 32'h0);
    check("R13 select unchanged", {29'b0, dr_shift_out}, {29'b0, 32'h1, OK});

    // R8: power handshake
    scan_dr(1'b0, 2'd2, 32'h0500_0030);
    scan_dr(1'b0, 2'd1, 32'h5000_0000);
    @(negedge clk);
    scan_dr(1'b1, 2'd1, 32'h0);
    check("R8 power ack", {29'b0, dr_shift_out}, {29'b0, 32'hF000_0000, OK});

    // R10: forwarded write
    scan_ir(4'hB);
    scan_dr(1'b0, 2'd1, 32'h8000_1000);
    check("R10 ack", {61'b0, dr_shift_out[2:0]}, {61'b0, OK});
    check("R10 fields", {22'b0, ap_req, ap_sel, ap_bank, ap_addr, ap_rnw, ap_wdata},
          {22'b0, 1'b1, 8'h05, 4'h3, 2'd1, 1'b0, 32'h8000_1000});
    @(negedge clk);
    check("R10 single pulse", {63'b0, ap_req}, 64'h0);

    // R9: error sets sticky; write 0 keeps, write 1 clears
    ap_respond(32'h0, 1'b1);
    scan_ir(4'hA);
    scan_dr(1'b1, 2'd1, 32'h0);
    check("R9 sticky set", {32'b0, dr_shift_out[34:3]}, {32'b0, 32'hF000_0020});
    scan_dr(1'b0, 2'd1, 32'h5000_0000);
    scan_dr(1'b1, 2'd1, 32'h0);
    check("R9 write 0 keeps", {32'b0, dr_shift_out[34:3]}, {32'b0, 32'hF000_0020});
    scan_dr(1'b0, 2'd1, 32'h5000_0020);
    scan_dr(1'b1, 2'd1, 32'h0);
    check("R9 w1c clears", {32'b0, dr_shift_out[34:3]}, {32'b0, 32'hF000_0000});
    scan_ir(4'hB);
    scan_dr(1'b0, 2'd0, 32'h0);
    ap_respond(32'h0, 1'b1);
    scan_ir(4'h8);
    scan_dr(1'b0, 2'd0, 32'h4);
    scan_ir(4'hA);
    scan_dr(1'b1, 2'd1, 32'h0);
    check("R9 abort clears", {32'b0, dr_shift_out[34:3]}, {32'b0, 32'hF000_0000});

    // R12: access-port read data reaches the read buffer
    scan_ir(4'hB);
    scan_dr(1'b1, 2'd3, 32'h0);
    check("R12 read request", {59'b0, ap_req, ap_rnw, ap_addr, 1'b0}, {59'b0, 1'b1, 1'b1, 2'd3, 1'b0});
    ap_respond(32'hCAFE_F00D, 1'b0);
    check("R12 data field", {32'b0, dr_shift_out[34:3]}, {32'b0, 32'hCAFE_F00D});
    scan_ir(4'hA);
    scan_dr(1'b1, 2'd3, 32'h0);
    check("R12 rdbuf read", {29'b0, dr_shift_out}, {29'b0, 32'hCAFE_F00D, OK});

    // R11: busy gives WAIT and no request
    scan_ir(4'hB);
    ap_busy = 1'b1;
    scan_dr(1'b1, 2'd0, 32'h0);
    check("R11 wait ack", {29'b0, dr_shift_out}, {29'b0, 32'hCAFE_F00D, WT});
    check("R11 no request", {63'b0, ap_req}, 64'h0);
    @(negedge clk);
    check("R11 still no request", {63'b0, ap_req}, 64'h0);
    ap_busy = 1'b0;
    scan_ir(4'hA);
    scan_dr(1'b1, 2'd3, 32'h0);
    check("R11 buffer kept", {29'b0, dr_shift_out}, {29'b0, 32'hCAFE_F00D, OK});

    finish_run();
  end
endmodule